// File: doc/BRIEF.md
# Nine-Bit Asynchronous Frame Transmitter

This block turns one buffer write into one 11-bit asynchronous serial frame on a single output line. A frame is a low start bit, eight payload bits with the least significant bit first, a ninth bit whose value software supplies with the write, and a high stop bit. The line rests high between frames.

All bit timing comes from a divide-by-16 sub-bit counter that runs from reset onward and never restarts. A rate-select input puts either a pass-through or a divide-by-2 stage in front of that counter, so one bit lasts 16 or 32 system clocks. A write is parked until the counter next rolls over. The start bit goes out on that rollover, and every later bit goes out on the rollover after it. The start latency therefore varies with the counter's phase at the moment of the write.

A sticky completion flag rises on the eleventh rollover after the write, which is the rollover that puts the stop bit on the line. The flag stays set until software pulses a clear input. A write made while a frame is parked or being shifted is dropped.

Top module: `nbit_frame_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_line` is 1 and `tx_done` is 0.
- R2: Each frame on `tx_line` is, in order: a 0 start bit, `wr_byte[0]` through `wr_byte[7]`, the `wr_ninth` value captured at the write, and a 1 stop bit.
- R3: One bit lasts 16 clock cycles when `fast_rate` is 1 and 32 cycles when it is 0.
- R4: The start bit begins on the first counter rollover strictly after the clock edge that accepts the write. It comes 1 to P cycles after that edge, where P is the bit period in cycles. `tx_line` changes only on rollover edges.
- R5: `tx_done` rises on the edge where the stop bit begins. That edge is the 11th rollover after the write and comes 10·P cycles after the start bit's edge. `tx_done` is 0 in the cycle before that edge, provided it was cleared earlier.
- R6: Once set, `tx_done` holds until `done_clr` is sampled high, and it is 0 on the cycle after that.
- R7: When `done_clr` is high on the same edge that sets `tx_done`, the set wins and `tx_done` is 1 afterwards.
- R8: A write sampled while a frame is waiting for its first rollover, or while it is being shifted, is dropped. No extra frame follows, and the frame in flight is unchanged.
- R9: `tx_line` is 1 whenever no frame is being shifted. A write made on the cycle after `tx_done` rises is accepted. Its frame follows the previous stop bit, and that stop bit lasts at least one full bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_rate | input | 1 | 1: bit period 16 clocks; 0: bit period 32 clocks |
| wr_en | input | 1 | Buffer write strobe, one cycle |
| wr_byte | input | 8 | Payload byte, sent LSB first |
| wr_ninth | input | 1 | Ninth frame bit |
| done_clr | input | 1 | Clears the completion flag |
| tx_line | output | 1 | Serial output, idle high |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
The flag's set, caused by the stop bit's rollover, and software's clear can land on the same clock edge. The bench measures where the start bit of a frame falls, counts forward ten bit periods, and raises `done_clr` so that it is sampled on exactly the edge that launches the stop bit. It then expects `tx_done` to read 1 on both following samples. A separate clear issued well away from any rollover must bring the flag to 0 on the next cycle.

// File: rtl/nft_pkg.sv
package nft_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned SUB_W   = 4;
    localparam int unsigned SHIFT_W = BYTE_W + 2;
    localparam int unsigned LEFT_W  = $clog2(SHIFT_W + 1);

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_WAIT,
        SER_SHIFT
    } ser_state_e;

    typedef struct packed {
        logic              ninth;
        logic [BYTE_W-1:0] data;
    } tx_word_t;

    // Bits that follow the start bit, LSB leaves first: data, ninth, stop.
    function automatic logic [SHIFT_W-1:0] frame_tail(input tx_word_t w);
        return {1'b1, w.ninth, w.data};
    endfunction

endpackage

// File: rtl/nft_tick_gen.sv
module nft_tick_gen #(
    parameter int unsigned SUB_W = nft_pkg::SUB_W
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    output logic roll
);
    logic             phase;
    logic             tick;
    logic [SUB_W-1:0] sub;

    assign tick = fast | phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            sub   <= '0;
        end else begin
            phase <= ~phase;
            if (tick) begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign roll = tick && (sub == {SUB_W{1'b1}});

endmodule

// File: rtl/nft_serializer.sv
module nft_serializer
    import nft_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     roll,
    input  logic     wr_en,
    input  tx_word_t wr_word,
    output logic     tx,
    output logic     busy,
    output logic     frame_end
);
    ser_state_e          state;
    tx_word_t            held;
    logic [SHIFT_W-1:0]  shreg;
    logic [LEFT_W-1:0]   left;

    assign busy      = (state != SER_IDLE);
    assign frame_end = (state == SER_SHIFT) && roll && (left == LEFT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            held  <= '0;
            shreg <= '1;
            left  <= '0;
            tx    <= 1'b1;
        end else begin
            unique case (state)
                SER_IDLE: begin
                    if (wr_en) begin
                        held  <= wr_word;
                        state <= SER_WAIT;
                    end
                end
                SER_WAIT: begin
                    if (roll) begin
                        tx    <= 1'b0;
                        shreg <= frame_tail(held);
                        left  <= LEFT_W'(SHIFT_W);
                        state <= SER_SHIFT;
                    end
                end
                SER_SHIFT: begin
                    if (roll) begin
                        tx    <= shreg[0];
                        shreg <= {1'b1, shreg[SHIFT_W-1:1]};
                        left  <= left - 1'b1;
                        if (left == LEFT_W'(1)) begin
                            state <= SER_IDLE;
                        end
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nft_done_flag.sv
module nft_done_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/nbit_frame_tx.sv
module nbit_frame_tx
    import nft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_rate,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              wr_ninth,
    input  logic              done_clr,
    output logic              tx_line,
    output logic              tx_done
);
    logic     roll;
    logic     busy;
    logic     frame_end;
    tx_word_t word_in;

    assign word_in = '{ninth: wr_ninth, data: wr_byte};

    nft_tick_gen #(.SUB_W(SUB_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .fast (fast_rate),
        .roll (roll)
    );

    nft_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .roll      (roll),
        .wr_en     (wr_en),
        .wr_word   (word_in),
        .tx        (tx_line),
        .busy      (busy),
        .frame_end (frame_end)
    );

    nft_done_flag u_done (
        .clk  (clk),
        .rst  (rst),
        .set  (frame_end),
        .clr  (done_clr),
        .flag (tx_done)
    );

endmodule

// File: rtl/nft_checker.sv
module nft_checker (
    input logic clk,
    input logic rst,
    input logic roll,
    input logic busy,
    input logic frame_end,
    input logic tx_line,
    input logic tx_done,
    input logic done_clr
);
    // R4
    line_moves_on_roll_chk: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(tx_line));

    // R5
    done_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && !tx_done) |=> !tx_done);

    // R6
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && done_clr && !frame_end) |=> !tx_done);

    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> tx_done);

    // R9
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);

    // R8
    busy_holds_between_rolls_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !roll) |=> busy);
endmodule

bind nbit_frame_tx nft_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .roll      (roll),
    .busy      (busy),
    .frame_end (frame_end),
    .tx_line   (tx_line),
    .tx_done   (tx_done),
    .done_clr  (done_clr)
);

// File: tb/test_nbit_frame_tx.sv
`timescale 1ns/1ps
module test_nbit_frame_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_rate = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       wr_ninth = 1'b0;
    logic       done_clr = 1'b0;
    logic       tx_line;
    logic       tx_done;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int period = 16;
    int last_wr = 0;
    int start_cyc = 0;
    int frames_started = 0;
    int frames_done = 0;
    int pushed = 0;
    bit mon_en = 1'b0;
    logic [8:0] expq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nbit_frame_tx i_nbit_frame_tx (
        .clk       (clk),
        .rst       (rst),
        .fast_rate (fast_rate),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .wr_ninth  (wr_ninth),
        .done_clr  (done_clr),
        .tx_line   (tx_line),
        .tx_done   (tx_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Driver: one write; accepted writes push their expected frame.
    task automatic send(input logic [7:0] d, input logic n9, input bit accepted);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_byte  = d;
        wr_ninth = n9;
        if (accepted) begin
            done_clr = 1'b1;
            expq.push_back({n9, d});
            pushed++;
            last_wr = cyc + 1;
        end
        @(negedge clk);
        wr_en    = 1'b0;
        done_clr = 1'b0;
    endtask

    // Monitor: find start bits, pop the scoreboard and compare.
    initial begin
        logic [8:0] exp_w;
        int s;
        int done_before;
        wait (mon_en);
        forever begin
            @(negedge clk);
            if (tx_line == 1'b0) begin
                s = cyc;
                start_cyc = s;
                frames_started++;
                if (expq.size() == 0) begin
                    check(1'b0, "R8 unexpected frame", 1, 0);
                    exp_w = '1;
                end else begin
                    exp_w = expq.pop_front();
                end
                // R4 start latency
                check((s - last_wr) >= 1 && (s - last_wr) <= period,
                      "R4 start latency", s - last_wr, period);
                wait_cyc(s + period / 2);
                // R2 start bit
                check(tx_line == 1'b0, "R2 start bit", tx_line, 0);
                for (int k = 1; k <= 9; k++) begin
                    wait_cyc(s + k * period + period / 2);
                    // R2 R3 payload bit at mid-period
                    check(tx_line == exp_w[k-1], "R2 R3 payload bit", tx_line, exp_w[k-1]);
                end
                wait_cyc(s + 10 * period - 1);
                done_before = tx_done;
                // R5 flag low before stop edge
                check(done_before == 0, "R5 flag early", done_before, 0);
                wait_cyc(s + 10 * period);
                // R5 flag rises with stop bit
                check(tx_done == 1'b1, "R5 flag at stop edge", tx_done, 1);
                wait_cyc(s + 10 * period + period / 2);
                // R2 R9 stop bit high
                check(tx_line == 1'b1, "R2 R9 stop bit", tx_line, 1);
                frames_done++;
            end
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int n;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(tx_line == 1'b1, "R1 line in reset", tx_line, 1);
        check(tx_done == 1'b0, "R1 flag in reset", tx_done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1, "R1 line after reset", tx_line, 1);
        check(tx_done == 1'b0, "R1 flag after reset", tx_done, 0);
        mon_en = 1'b1;

        // R2 R3 fast rate frame
        period = 16;
        send(8'hA5, 1'b1, 1'b1);
        wait (frames_done == 1);
        repeat (40) @(negedge clk);
        check(tx_done == 1'b1, "R6 flag holds", tx_done, 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(tx_done == 1'b0, "R6 flag cleared", tx_done, 0);

        // R8 writes while waiting and while shifting are dropped
        send(8'h3C, 1'b0, 1'b1);
        send(8'hFF, 1'b1, 1'b0);
        wait (frames_started == 2);
        repeat (40) @(negedge clk);
        send(8'h00, 1'b1, 1'b0);
        wait (frames_done == 2);
        repeat (3 * period) @(negedge clk);
        check(frames_started == 2, "R8 no extra frame", frames_started, 2);

        // R3 slow rate frames
        @(negedge clk);
        fast_rate = 1'b0;
        period = 32;
        send(8'h01, 1'b0, 1'b1);
        wait (frames_done == 3);
        send(8'h80, 1'b1, 1'b1);
        wait (frames_done == 4);

        // R7 clear and set on the same edge
        send(8'h5A, 1'b0, 1'b1);
        wait (frames_started == 5);
        wait_cyc(start_cyc + 10 * period - 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        @(negedge clk);
        check(tx_done == 1'b1, "R7 set wins over clear", tx_done, 1);
        wait (frames_done == 5);

        // R9 back-to-back: write right after the flag rises
        @(negedge clk);
        fast_rate = 1'b1;
        period = 16;
        repeat (20) @(negedge clk);
        send(8'hC3, 1'b1, 1'b1);
        wait (frames_started == 6);
        wait_cyc(start_cyc + 10 * period);
        send(8'h96, 1'b0, 1'b1);
        wait (frames_done == 7);

        // R4 vary write phase against the free-running counter
        for (int k = 0; k < 5; k++) begin
            repeat (k * 3 + 1) @(negedge clk);
            n = frames_done;
            send(8'(8'h11 * (k + 1)), k[0], 1'b1);
            wait (frames_done == n + 1);
        end

        repeat (4 * period) @(negedge clk);
        check(frames_done == pushed, "R8 frame count", frames_done, pushed);
        check(tx_line == 1'b1, "R9 idle line", tx_line, 1);
        report();
    end

endmodule